// File: doc/BRIEF.md
# Dual-Bank Write Admission and Sector Protection Gate

This block sits in front of a flash array split into a large bank (three quarters of the 1M-word space) and a small bank (the remaining quarter). Every cycle it may receive one request: a read, a word program, a sector erase, a block erase or a chip erase. It decides whether each write request may start, and it records which bank is being written until the array reports the end of that write. While one bank is being written, reads to the other bank still go to the array. Reads to the bank under write are sent to the status path instead.

A hardware protect input, active low, shields the four outermost 1 KWord sectors of the large bank. While protection is active, a program or erase that would touch them is refused. A chip erase is accepted under protection. For its whole duration the block reports the first protected sector index and the number of sectors the erase engine must skip. The protect input is sampled once, when the write is accepted. A parameter places the large bank at the bottom of the map (protected words 00000h–00FFFh) or at the top (protected words FF000h–FFFFFh).

All outputs are registered. A request presented at a clock edge has its decision visible after that edge.

Top module: `bankgate_top`

## Requirements
- R1: After reset, busy, chipEraseActive, reqGrant, reqReject, rdToArray and rdToStatus are all 0, and skipCount is 0.
- R2: The bank index is 0 for the large bank and 1 for the small bank. With TOP_PROT=0 the large bank covers words 00000h–BFFFFh. With TOP_PROT=1 it covers words 40000h–FFFFFh.
- R3: A read (reqKind 0) gives a one-cycle pulse on rdToStatus when the block is busy and the read targets the busy bank, or when a chip erase is active. Otherwise it gives a one-cycle pulse on rdToArray. The two pulses are never raised together.
- R4: A write request (reqKind 1 program, 2 sector erase, 3 block erase, 4 chip erase) that arrives while the block is idle and is not refused for protection gives a one-cycle reqGrant pulse. It sets busy, and busyBank takes the target bank.
- R5: A write request that arrives while busy gives a one-cycle reqReject pulse with no reqGrant, and busy and busyBank keep their values.
- R6: opDone while busy clears busy, and clears chipEraseActive, on the next edge. opDone while idle has no effect.
- R7: With protectN low, a program or sector erase whose sector index (address bits 19..10) lies in the four protected sectors is rejected. An address outside them is granted. With protectN high, the same addresses are granted.
- R8: With protectN low, a block erase whose block index (address bits 19..15) is the block holding the protected sectors is rejected as a whole. Other blocks are granted.
- R9: A granted chip erase sets chipEraseActive. skipFirst is the first protected sector index (0 for the bottom variant, 3FCh for the top). skipCount is 4 if protectN was low at acceptance and 0 otherwise. skipCount stays constant until the erase ends, whatever protectN does in the meantime.
- R10: Requests with reqKind 5, 6 or 7 are ignored: no pulse is produced and busy does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| reqValid | input | 1 | A request is present this cycle |
| reqKind | input | 3 | 0 read, 1 program, 2 sector erase, 3 block erase, 4 chip erase |
| reqAddr | input | ADDR_W | Word address of the request |
| protectN | input | 1 | Protect input, low shields the edge sectors |
| opDone | input | 1 | Array reports the running write has finished |
| reqGrant | output | 1 | Write accepted (one-cycle pulse) |
| reqReject | output | 1 | Write refused (one-cycle pulse) |
| rdToArray | output | 1 | Read served from the array (one-cycle pulse) |
| rdToStatus | output | 1 | Read routed to status (one-cycle pulse) |
| busy | output | 1 | A write is running |
| busyBank | output | 1 | Bank of the running write |
| chipEraseActive | output | 1 | The running write is a chip erase |
| skipFirst | output | ADDR_W-SECTOR_BITS | First sector index to skip during chip erase |
| skipCount | output | $clog2(PROT_SECTORS+1) | Number of sectors to skip during chip erase |

## Verification
On every cycle the assertions check the following. Grant and reject are never raised together, and neither are the two read routes. A write arriving while busy is always refused. busy only rises together with a grant and always falls after opDone. A non-zero skip count exists only inside a chip erase, and it holds steady there. Other behaviour can only be shown by the bench's scenarios: which addresses fall in which bank for each orientation, which sectors and blocks count as protected, that protection is ignored when the input is high, and the exact skip values reported for both orientations.

// File: rtl/bankgate_pkg.sv
package bankgate_pkg;

  typedef enum logic [2:0] {
    KIND_READ  = 3'd0,
    KIND_PROG  = 3'd1,
    KIND_SECT  = 3'd2,
    KIND_BLOCK = 3'd3,
    KIND_CHIP  = 3'd4
  } reqKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchSkip;
    logic clearSkip;
  } dpStrobe_t;

endpackage

// File: rtl/bankgate_dp.sv
module bankgate_dp
  import bankgate_pkg::*;
#(
  parameter int ADDR_W       = 20,
  parameter int SECTOR_BITS  = 10,
  parameter int BLOCK_BITS   = 15,
  parameter int SMALL_BLOCKS = 8,
  parameter int PROT_SECTORS = 4,
  parameter bit TOP_PROT     = 1'b0,
  localparam int SEC_W       = ADDR_W - SECTOR_BITS,
  localparam int CNT_W       = $clog2(PROT_SECTORS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [2:0]        reqKind,
  input  logic              protectN,
  input  dpStrobe_t         strobe,
  output logic              bankSel,
  output logic              protHit,
  output logic [SEC_W-1:0]  skipFirst,
  output logic [CNT_W-1:0]  skipCount
);

  localparam int BLK_W       = ADDR_W - BLOCK_BITS;
  localparam int NUM_SEC     = 1 << SEC_W;
  localparam int SMALL_WORDS = SMALL_BLOCKS << BLOCK_BITS;
  localparam int LARGE_WORDS = (1 << ADDR_W) - SMALL_WORDS;
  localparam int PROT_FIRST  = TOP_PROT ? (NUM_SEC - PROT_SECTORS) : 0;
  localparam logic [SEC_W-1:0] PROT_LO  = SEC_W'(PROT_FIRST);
  localparam logic [SEC_W-1:0] PROT_HI  = SEC_W'(PROT_FIRST + PROT_SECTORS - 1);
  localparam logic [BLK_W-1:0] PROT_BLK = BLK_W'(PROT_FIRST >> (BLOCK_BITS - SECTOR_BITS));
  localparam logic [CNT_W-1:0] SKIP_N   = CNT_W'(PROT_SECTORS);

  logic [SEC_W-1:0] secIdx;
  logic [BLK_W-1:0] blkIdx;
  logic             secInProt;
  logic             blkInProt;

  assign secIdx    = reqAddr[ADDR_W-1:SECTOR_BITS];
  assign blkIdx    = reqAddr[ADDR_W-1:BLOCK_BITS];
  assign secInProt = (secIdx >= PROT_LO) && (secIdx <= PROT_HI);
  assign blkInProt = (blkIdx == PROT_BLK);

  // bank orientation picked by parameter
  generate
    if (TOP_PROT) begin : g_largeTop
      assign bankSel = (reqAddr < ADDR_W'(SMALL_WORDS));
    end else begin : g_largeBottom
      assign bankSel = (reqAddr >= ADDR_W'(LARGE_WORDS));
    end
  endgenerate

  always_comb begin
    protHit = 1'b0;
    if (!protectN) begin
      case (reqKind)
        KIND_PROG, KIND_SECT: protHit = secInProt;
        KIND_BLOCK:           protHit = blkInProt;
        default:              protHit = 1'b0;
      endcase
    end
  end

  // chip-erase skip list, frozen at acceptance
  always_ff @(posedge clk) begin
    if (!rstN) begin
      skipFirst <= '0;
      skipCount <= '0;
    end else if (strobe.clearSkip) begin
      skipCount <= '0;
    end else if (strobe.latchSkip) begin
      skipFirst <= PROT_LO;
      skipCount <= protectN ? '0 : SKIP_N;
    end
  end

  p_skip_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.latchSkip && !strobe.clearSkip) |=> $stable(skipCount));

endmodule

// File: rtl/bankgate_ctrl.sv
module bankgate_ctrl
  import bankgate_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic [2:0] reqKind,
  input  logic      opDone,
  input  logic      bankSel,
  input  logic      protHit,
  output dpStrobe_t strobe,
  output logic      reqGrant,
  output logic      reqReject,
  output logic      rdToArray,
  output logic      rdToStatus,
  output logic      busy,
  output logic      busyBank,
  output logic      chipEraseActive
);

  logic isRead;
  logic isWrite;
  logic isChip;
  logic acceptWr;
  logic readHitsBusy;

  assign isRead       = reqValid && (reqKind == KIND_READ);
  assign isWrite      = reqValid && (reqKind >= KIND_PROG) && (reqKind <= KIND_CHIP);
  assign isChip       = (reqKind == KIND_CHIP);
  assign acceptWr     = isWrite && !busy && !protHit;
  assign readHitsBusy = busy && (chipEraseActive || (bankSel == busyBank));

  assign strobe.latchSkip = acceptWr && isChip;
  assign strobe.clearSkip = busy && opDone;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqGrant        <= 1'b0;
      reqReject       <= 1'b0;
      rdToArray       <= 1'b0;
      rdToStatus      <= 1'b0;
      busy            <= 1'b0;
      busyBank        <= 1'b0;
      chipEraseActive <= 1'b0;
    end else begin
      reqGrant   <= 1'b0;
      reqReject  <= 1'b0;
      rdToArray  <= 1'b0;
      rdToStatus <= 1'b0;
      if (busy && opDone) begin
        busy            <= 1'b0;
        chipEraseActive <= 1'b0;
      end
      if (isRead) begin
        rdToStatus <= readHitsBusy;
        rdToArray  <= !readHitsBusy;
      end
      if (isWrite) begin
        if (acceptWr) begin
          reqGrant        <= 1'b1;
          busy            <= 1'b1;
          busyBank        <= bankSel;
          chipEraseActive <= isChip;
        end else begin
          reqReject <= 1'b1;
        end
      end
    end
  end

  p_reject_keeps_bank_r5: assert property (@(posedge clk) disable iff (!rstN)
    reqReject |-> $stable(busyBank));

  p_chip_implies_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    chipEraseActive |-> busy);

endmodule

// File: rtl/bankgate_top.sv
module bankgate_top
  import bankgate_pkg::*;
#(
  parameter int ADDR_W       = 20,
  parameter int SECTOR_BITS  = 10,
  parameter int BLOCK_BITS   = 15,
  parameter int SMALL_BLOCKS = 8,
  parameter int PROT_SECTORS = 4,
  parameter bit TOP_PROT     = 1'b0,
  localparam int SEC_W       = ADDR_W - SECTOR_BITS,
  localparam int CNT_W       = $clog2(PROT_SECTORS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [2:0]        reqKind,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              protectN,
  input  logic              opDone,
  output logic              reqGrant,
  output logic              reqReject,
  output logic              rdToArray,
  output logic              rdToStatus,
  output logic              busy,
  output logic              busyBank,
  output logic              chipEraseActive,
  output logic [SEC_W-1:0]  skipFirst,
  output logic [CNT_W-1:0]  skipCount
);

  dpStrobe_t strobe;
  logic      bankSel;
  logic      protHit;

  bankgate_dp #(
    .ADDR_W(ADDR_W), .SECTOR_BITS(SECTOR_BITS), .BLOCK_BITS(BLOCK_BITS),
    .SMALL_BLOCKS(SMALL_BLOCKS), .PROT_SECTORS(PROT_SECTORS), .TOP_PROT(TOP_PROT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .reqAddr(reqAddr), .reqKind(reqKind),
    .protectN(protectN), .strobe(strobe), .bankSel(bankSel), .protHit(protHit),
    .skipFirst(skipFirst), .skipCount(skipCount)
  );

  bankgate_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .opDone(opDone), .bankSel(bankSel), .protHit(protHit), .strobe(strobe),
    .reqGrant(reqGrant), .reqReject(reqReject), .rdToArray(rdToArray),
    .rdToStatus(rdToStatus), .busy(busy), .busyBank(busyBank),
    .chipEraseActive(chipEraseActive)
  );

  p_pulse_excl_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(reqGrant && reqReject));

  p_route_onehot_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rdToArray, rdToStatus}));

  p_busy_write_reject_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && reqValid && (reqKind >= 3'd1) && (reqKind <= 3'd4)) |=> (reqReject && !reqGrant));

  p_busy_rise_grant_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> reqGrant);

  p_done_release_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && opDone) |=> !busy);

  p_skip_in_chip_r9: assert property (@(posedge clk) disable iff (!rstN)
    (skipCount != '0) |-> chipEraseActive);

  p_skip_stable_r9: assert property (@(posedge clk) disable iff (!rstN)
    (chipEraseActive && !$rose(chipEraseActive)) |-> $stable(skipCount));

endmodule

// File: tb/tb_bankgate_top.sv
module tb_bankgate_top;

  localparam int CYC = 20;

  logic clk = 1'b0;
  always #(CYC/2) clk = ~clk;

  logic rstN;
  logic bValid, bPn, bDone;
  logic [2:0] bKind;
  logic [19:0] bAddr;
  logic bGrant, bReject, bArr, bStat, bBusy, bBank, bChip;
  logic [9:0] bSkipFirst;
  logic [2:0] bSkipCnt;

  logic tValid, tPn, tDone;
  logic [2:0] tKind;
  logic [19:0] tAddr;
  logic tGrant, tReject, tArr, tStat, tBusy, tBank, tChip;
  logic [9:0] tSkipFirst;
  logic [2:0] tSkipCnt;

  bankgate_top dut (
    .clk(clk), .rstN(rstN), .reqValid(bValid), .reqKind(bKind), .reqAddr(bAddr),
    .protectN(bPn), .opDone(bDone), .reqGrant(bGrant), .reqReject(bReject),
    .rdToArray(bArr), .rdToStatus(bStat), .busy(bBusy), .busyBank(bBank),
    .chipEraseActive(bChip), .skipFirst(bSkipFirst), .skipCount(bSkipCnt));

  bankgate_top #(.TOP_PROT(1'b1)) dutTop (
    .clk(clk), .rstN(rstN), .reqValid(tValid), .reqKind(tKind), .reqAddr(tAddr),
    .protectN(tPn), .opDone(tDone), .reqGrant(tGrant), .reqReject(tReject),
    .rdToArray(tArr), .rdToStatus(tStat), .busy(tBusy), .busyBank(tBank),
    .chipEraseActive(tChip), .skipFirst(tSkipFirst), .skipCount(tSkipCnt));

  int checks = 0;
  int errors = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  typedef struct packed {
    logic        v;
    logic [2:0]  kind;
    logic [19:0] addr;
    logic        pn;
    logic        dn;
    logic        eG;
    logic        eR;
    logic        eA;
    logic        eS;
    logic        eB;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [0:NV-1] = '{
    '{1'b1, 3'd0, 20'h00000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R3 idle read
    '{1'b1, 3'd1, 20'hC1234, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}, // R4 small bank
    '{1'b1, 3'd0, 20'h10000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1}, // R3 other bank
    '{1'b1, 3'd0, 20'hC0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1}, // R2 R3 busy bank
    '{1'b1, 3'd1, 20'h20000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1}, // R5
    '{1'b0, 3'd0, 20'h00000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R6
    '{1'b1, 3'd1, 20'h00800, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R7 protected
    '{1'b1, 3'd1, 20'h01000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}, // R7 just outside
    '{1'b0, 3'd0, 20'h00000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R6
    '{1'b1, 3'd2, 20'h00C00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}, // R7 protect off
    '{1'b0, 3'd0, 20'h00000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R6
    '{1'b1, 3'd3, 20'h07000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R8 overlap
    '{1'b1, 3'd3, 20'h08000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}, // R8 next block
    '{1'b1, 3'd0, 20'hF0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1}, // R2 R3
    '{1'b0, 3'd0, 20'h00000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R6
    '{1'b1, 3'd2, 20'hFFC00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}, // R7 top not protected
    '{1'b0, 3'd0, 20'h00000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R6
    '{1'b1, 3'd5, 20'h00000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}  // R10 unused code
  };

  task automatic stepB(input logic v, input logic [2:0] k, input logic [19:0] a,
                       input logic pn, input logic dn);
    bValid = v; bKind = k; bAddr = a; bPn = pn; bDone = dn;
    @(posedge clk);
    @(negedge clk);
    bValid = 1'b0; bDone = 1'b0;
  endtask

  task automatic stepT(input logic v, input logic [2:0] k, input logic [19:0] a,
                       input logic pn, input logic dn);
    tValid = v; tKind = k; tAddr = a; tPn = pn; tDone = dn;
    @(posedge clk);
    @(negedge clk);
    tValid = 1'b0; tDone = 1'b0;
  endtask

  initial begin
    #(CYC * 100000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    bValid = 0; bKind = 0; bAddr = 0; bPn = 1; bDone = 0;
    tValid = 0; tKind = 0; tAddr = 0; tPn = 1; tDone = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 busy", bBusy, 0);
    chk("R1 grant", bGrant, 0);
    chk("R1 reject", bReject, 0);
    chk("R1 routes", {bArr, bStat}, 0);
    chk("R1 chip", bChip, 0);
    chk("R1 skipCount", bSkipCnt, 0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      stepB(VECS[i].v, VECS[i].kind, VECS[i].addr, VECS[i].pn, VECS[i].dn);
      chk($sformatf("vec%0d grant R4", i), bGrant, VECS[i].eG);
      chk($sformatf("vec%0d reject R5", i), bReject, VECS[i].eR);
      chk($sformatf("vec%0d array R3", i), bArr, VECS[i].eA);
      chk($sformatf("vec%0d status R3", i), bStat, VECS[i].eS);
      chk($sformatf("vec%0d busy R6", i), bBusy, VECS[i].eB);
    end

    // R4 busyBank, R5 rejected write keeps it
    stepB(1, 3'd1, 20'hC0010, 1, 0);
    chk("R4 busyBank small", bBank, 1);
    stepB(1, 3'd2, 20'h00000, 1, 0);
    chk("R5 busyBank kept", bBank, 1);
    stepB(0, 3'd0, 20'h0, 1, 1);
    stepB(1, 3'd1, 20'hBFFFF, 1, 0);
    chk("R2 R4 busyBank large edge", bBank, 0);
    stepB(0, 3'd0, 20'h0, 1, 1);
    stepB(0, 3'd0, 20'h0, 1, 1);
    chk("R6 done while idle", {bBusy, bGrant, bReject}, 0);

    // R9 chip erase under protection
    stepB(1, 3'd4, 20'h05555, 0, 0);
    chk("R9 chip grant", bGrant, 1);
    chk("R9 chip active", bChip, 1);
    chk("R9 skipCount", bSkipCnt, 4);
    chk("R9 skipFirst", bSkipFirst, 10'h000);
    stepB(1, 3'd0, 20'h00000, 1, 0);
    chk("R3 R9 read large during chip", bStat, 1);
    stepB(1, 3'd0, 20'hF0000, 1, 0);
    chk("R3 R9 read small during chip", bStat, 1);
    stepB(0, 3'd0, 20'h0, 1, 0);
    chk("R9 skip held after protect high", bSkipCnt, 4);
    stepB(1, 3'd1, 20'h40000, 1, 0);
    chk("R5 write during chip", bReject, 1);
    stepB(0, 3'd0, 20'h0, 1, 1);
    chk("R6 chip cleared", {bBusy, bChip}, 0);
    chk("R9 skip cleared", bSkipCnt, 0);
    stepB(1, 3'd4, 20'h05555, 1, 0);
    chk("R9 chip unprotected", {bGrant, bSkipCnt}, {1'b1, 3'd0});
    stepB(0, 3'd0, 20'h0, 1, 1);

    // R10 ignored code while busy leaves state
    stepB(1, 3'd2, 20'h80000, 1, 0);
    stepB(1, 3'd7, 20'h80000, 0, 0);
    chk("R10 ignored while busy", {bGrant, bReject, bArr, bStat, bBusy}, 5'b00001);
    stepB(0, 3'd0, 20'h0, 1, 1);

    // top orientation, R2 R7 R8 R9
    stepT(1, 3'd1, 20'hFF000, 0, 0);
    chk("R7 top protected", tReject, 1);
    stepT(1, 3'd3, 20'hF8000, 0, 0);
    chk("R8 top block overlap", tReject, 1);
    stepT(1, 3'd1, 20'hFEFFF, 0, 0);
    chk("R7 top outside", tGrant, 1);
    chk("R2 top busyBank large", tBank, 0);
    stepT(1, 3'd0, 20'h3FFFF, 1, 0);
    chk("R2 R3 top small idle", tArr, 1);
    stepT(1, 3'd0, 20'h40000, 1, 0);
    chk("R2 R3 top large busy", tStat, 1);
    stepT(0, 3'd0, 20'h0, 1, 1);
    stepT(1, 3'd4, 20'h00000, 0, 0);
    chk("R9 top skipFirst", tSkipFirst, 10'h3FC);
    chk("R9 top skipCount", tSkipCnt, 4);
    stepT(0, 3'd0, 20'h0, 1, 1);
    chk("R6 top release", tBusy, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule